// File: doc/BRIEF.md
# Single-Register Load/Store Execution Unit

This unit carries out one single-register load or store for a 32-bit RISC core. A decoded 32-bit opcode arrives with a start strobe. The unit reads the base and transfer registers from a 16-entry register file through two combinational read ports. It forms the effective address from the base and an offset. The offset is either the 12-bit immediate in the opcode or an already-shifted register value that arrives on a port. The unit then runs exactly one bus transaction: a byte or word read, or a byte or word write.

When the transaction is acknowledged, the unit aligns the returned data and makes two register-file writes, each a one-cycle strobe. One write carries the load result to the transfer register. The other carries the updated base to the base register.

The unit handles the cases that come from the core's pipeline and its address rules:
- When the program counter is the base, it uses an adjusted PC value.
- When the program counter is the store source, it adds an offset to the stored value.
- An unaligned word load returns the word rotated.
- When a load targets its own base register, the loaded value is kept and the writeback is dropped.

Top module: `ldst_xfer_unit`

## Requirements
- R1: After reset, and while no instruction is in flight, mem_req, rf_wb_en and rf_ld_en are low and busy is low.
- R2: The base index is opcode[19:16]. When it is 15, the base is pc+8 for a load and pc+12 for a store. Otherwise the base is the value on rf_rdata_base.
- R3: When opcode[25] is 0, the offset is opcode[11:0] zero-extended. When opcode[25] is 1, the offset is the value on shifted_off.
- R4: When opcode[23] is 1, the modified base is base+offset. When opcode[23] is 0, it is base-offset. Both wrap modulo 2^32.
- R5: When opcode[24] is 1, mem_addr is the modified base. When opcode[24] is 0, mem_addr is the unmodified base.
- R6: rf_wb_en pulses with rf_wb_addr = base index and rf_wb_data = modified base when opcode[24]=0. It also pulses when opcode[24]=1 and opcode[21]=1. Otherwise it stays low.
- R7: A word load (opcode[20]=1, opcode[22]=0) uses mem_size=1. The loaded value is mem_rdata rotated right by 8 times mem_addr[1:0].
- R8: A byte load (opcode[22]=1) uses mem_size=0. The loaded value is byte lane mem_addr[1:0] of mem_rdata, with lane 0 in bits [7:0], zero-extended to 32 bits.
- R9: A store (opcode[20]=0) drives mem_we=1. The source index is opcode[15:12]. The store data is rf_rdata_data, or rf_rdata_data+8 when the index is 15. A byte store carries only the low 8 bits of that value, and the upper 24 bits of mem_wdata are zero.
- R10: When a load's transfer index equals its base index and writeback applies, rf_ld_en pulses with the loaded value and rf_wb_en stays low.
- R11: mem_req stays high with address, size, write-enable and data stable until mem_ack. rf_ld_en (for loads) and rf_wb_en pulse for exactly one cycle, in the cycle after mem_ack.
- R12: A start strobe while busy is high is ignored. It does not change the bus outputs and does not cause a second transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode valid, accepted when idle |
| opcode | input | 32 | Decoded load/store opcode |
| shifted_off | input | 32 | Pre-shifted register offset |
| pc | input | 32 | Program counter of the instruction |
| busy | output | 1 | Instruction in flight |
| rf_raddr_base | output | 4 | Base register read index |
| rf_rdata_base | input | 32 | Base register read data |
| rf_raddr_data | output | 4 | Transfer register read index |
| rf_rdata_data | input | 32 | Transfer register read data |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write enable |
| mem_size | output | 1 | 0 byte, 1 word |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data |
| mem_ack | input | 1 | Bus acknowledge |
| rf_wb_en | output | 1 | Base writeback strobe |
| rf_wb_addr | output | 4 | Base writeback index |
| rf_wb_data | output | 32 | Base writeback value |
| rf_ld_en | output | 1 | Load result strobe |
| rf_ld_addr | output | 4 | Load destination index |
| rf_ld_data | output | 32 | Load result value |

## Verification
The bench uses PC-relative loads and stores to catch a design that applies the same PC adjustment to both. Such a design misses by four bytes on one of them. It runs word loads at all four byte offsets, which exposes a shift in the wrong direction or a missing rotation. It runs byte loads from the upper lanes, where a design that returns lane 0, or that sign-extends, gives the wrong value.

Subtracting offsets that underflow past zero checks the wraparound. Loads whose destination is their own base show whether the writeback is wrongly allowed to win. Strobes sent during long acknowledge waits expose a unit that restarts or retargets its transaction.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int XW    = 32;
  localparam int IDXW  = 4;
  localparam int IMMW  = 12;

  localparam int BIT_REGOFF = 25;
  localparam int BIT_PRE    = 24;
  localparam int BIT_UP     = 23;
  localparam int BIT_BYTE   = 22;
  localparam int BIT_WB     = 21;
  localparam int BIT_LOAD   = 20;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } seq_t;

  typedef struct packed {
    logic            load;
    logic            byte_x;
    logic            wb;
    logic [IDXW-1:0] rn;
    logic [IDXW-1:0] rd;
  } xfer_ctrl_t;
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
  parameter int XW       = 32,
  parameter int IMMW     = 12,
  parameter int IDXW     = 4,
  parameter int PC_LD_ADJ = 8,
  parameter int PC_ST_ADJ = 12
) (
  input  logic            load,
  input  logic            regoff,
  input  logic            up,
  input  logic            pre,
  input  logic [IDXW-1:0] rn,
  input  logic [XW-1:0]   rf_base,
  input  logic [XW-1:0]   pc,
  input  logic [IMMW-1:0] imm,
  input  logic [XW-1:0]   shifted_off,
  output logic [XW-1:0]   addr,
  output logic [XW-1:0]   new_base
);
  localparam logic [IDXW-1:0] PC_IDX = {IDXW{1'b1}};
  localparam logic [XW-1:0]   LD_ADJ = XW'(PC_LD_ADJ);
  localparam logic [XW-1:0]   ST_ADJ = XW'(PC_ST_ADJ);

  logic [XW-1:0] base;
  logic [XW-1:0] offset;

  always_comb begin
    if (rn == PC_IDX) begin
      base = pc + (load ? LD_ADJ : ST_ADJ);
    end else begin
      base = rf_base;
    end
  end

  always_comb begin
    if (regoff) begin
      offset = shifted_off;
    end else begin
      offset = {{(XW-IMMW){1'b0}}, imm};
    end
  end

  always_comb begin
    if (up) begin
      new_base = base + offset;
    end else begin
      new_base = base - offset;
    end
    addr = pre ? new_base : base;
  end
endmodule

// File: rtl/ldst_store_fmt.sv
module ldst_store_fmt #(
  parameter int XW       = 32,
  parameter int IDXW     = 4,
  parameter int PC_SRC_ADJ = 8
) (
  input  logic            byte_x,
  input  logic [IDXW-1:0] rd,
  input  logic [XW-1:0]   rf_data,
  output logic [XW-1:0]   wdata
);
  localparam logic [IDXW-1:0] PC_IDX  = {IDXW{1'b1}};
  localparam logic [XW-1:0]   SRC_ADJ = XW'(PC_SRC_ADJ);

  logic [XW-1:0] src;

  always_comb begin
    src = (rd == PC_IDX) ? (rf_data + SRC_ADJ) : rf_data;
    if (byte_x) begin
      wdata = {{(XW-8){1'b0}}, src[7:0]};
    end else begin
      wdata = src;
    end
  end
endmodule

// File: rtl/ldst_load_align.sv
module ldst_load_align #(
  parameter int XW = 32
) (
  input  logic                    byte_x,
  input  logic [$clog2(XW/8)-1:0] lane,
  input  logic [XW-1:0]           rdata,
  output logic [XW-1:0]           value
);
  localparam int LANES = XW / 8;

  logic [XW-1:0] rot   [LANES];
  logic [7:0]    bytes [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_zero
      assign rot[k] = rdata;
    end else begin : g_rot
      assign rot[k] = {rdata[8*k-1:0], rdata[XW-1:8*k]};
    end
    assign bytes[k] = rdata[8*k +: 8];
  end

  always_comb begin
    if (byte_x) begin
      value = {{(XW-8){1'b0}}, bytes[lane]};
    end else begin
      value = rot[lane];
    end
  end

  always_comb begin
    if (byte_x) begin
      a_r8_zext: assert (value[XW-1:8] == '0);
    end
  end
endmodule

// File: rtl/ldst_xfer_unit.sv
module ldst_xfer_unit
  import ldst_pkg::*;
#(
  parameter int PC_LD_ADJ  = 8,
  parameter int PC_ST_ADJ  = 12,
  parameter int PC_SRC_ADJ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XW-1:0]   opcode,
  input  logic [XW-1:0]   shifted_off,
  input  logic [XW-1:0]   pc,
  output logic            busy,
  output logic [IDXW-1:0] rf_raddr_base,
  input  logic [XW-1:0]   rf_rdata_base,
  output logic [IDXW-1:0] rf_raddr_data,
  input  logic [XW-1:0]   rf_rdata_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_size,
  output logic [XW-1:0]   mem_addr,
  output logic [XW-1:0]   mem_wdata,
  input  logic [XW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic            rf_wb_en,
  output logic [IDXW-1:0] rf_wb_addr,
  output logic [XW-1:0]   rf_wb_data,
  output logic            rf_ld_en,
  output logic [IDXW-1:0] rf_ld_addr,
  output logic [XW-1:0]   rf_ld_data
);
  localparam int LANEW = $clog2(XW/8);

  seq_t          state_q, state_d;
  xfer_ctrl_t    ctrl_q, ctrl_d;
  logic [XW-1:0] addr_q, nbase_q, wdata_q, ldval_q;
  logic          accept, ack_take;

  logic [XW-1:0] addr_c, nbase_c, wdata_c, ldval_c;
  logic          pre_c;

  assign rf_raddr_base = opcode[19:16];
  assign rf_raddr_data = opcode[15:12];
  assign pre_c         = opcode[BIT_PRE];

  ldst_addr_gen #(
    .XW(XW), .IMMW(IMMW), .IDXW(IDXW),
    .PC_LD_ADJ(PC_LD_ADJ), .PC_ST_ADJ(PC_ST_ADJ)
  ) u_agen (
    .load        (opcode[BIT_LOAD]),
    .regoff      (opcode[BIT_REGOFF]),
    .up          (opcode[BIT_UP]),
    .pre         (pre_c),
    .rn          (opcode[19:16]),
    .rf_base     (rf_rdata_base),
    .pc          (pc),
    .imm         (opcode[IMMW-1:0]),
    .shifted_off (shifted_off),
    .addr        (addr_c),
    .new_base    (nbase_c)
  );

  ldst_store_fmt #(
    .XW(XW), .IDXW(IDXW), .PC_SRC_ADJ(PC_SRC_ADJ)
  ) u_sfmt (
    .byte_x  (opcode[BIT_BYTE]),
    .rd      (opcode[15:12]),
    .rf_data (rf_rdata_data),
    .wdata   (wdata_c)
  );

  ldst_load_align #(.XW(XW)) u_lalign (
    .byte_x (ctrl_q.byte_x),
    .lane   (addr_q[LANEW-1:0]),
    .rdata  (mem_rdata),
    .value  (ldval_c)
  );

  // next-state
  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    ack_take = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        accept  = 1'b1;
        state_d = ST_BUS;
      end
      ST_BUS: if (mem_ack) begin
        ack_take = 1'b1;
        state_d  = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl_d.load   = opcode[BIT_LOAD];
    ctrl_d.byte_x = opcode[BIT_BYTE];
    ctrl_d.wb     = !opcode[BIT_PRE] || opcode[BIT_WB];
    ctrl_d.rn     = opcode[19:16];
    ctrl_d.rd     = opcode[15:12];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      nbase_q <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      ctrl_q  <= ctrl_d;
      addr_q  <= addr_c;
      nbase_q <= nbase_c;
      wdata_q <= wdata_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldval_q <= '0;
    end else if (ack_take) begin
      ldval_q <= ldval_c;
    end
  end

  // outputs
  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_BUS);
  assign mem_we    = !ctrl_q.load;
  assign mem_size  = !ctrl_q.byte_x;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  logic ld_hits_base;
  assign ld_hits_base = ctrl_q.load && (ctrl_q.rd == ctrl_q.rn);

  assign rf_wb_en   = (state_q == ST_RESP) && ctrl_q.wb && !ld_hits_base;
  assign rf_wb_addr = ctrl_q.rn;
  assign rf_wb_data = nbase_q;
  assign rf_ld_en   = (state_q == ST_RESP) && ctrl_q.load;
  assign rf_ld_addr = ctrl_q.rd;
  assign rf_ld_data = ldval_q;

  // assertions
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)
                               && $stable(mem_we) && $stable(mem_size)));

  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wb_en || rf_ld_en) |=> (!rf_wb_en && !rf_ld_en));

  a_r11_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wb_en || rf_ld_en) |-> $past(mem_req && mem_ack));

  a_r10_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_wb_en && rf_ld_en && (rf_wb_addr == rf_ld_addr)));

  a_r12_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> !(rf_wb_en || rf_ld_en));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rf_wb_en && !rf_ld_en));
endmodule

// File: tb/ldst_xfer_unit_tb.sv
module ldst_xfer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] opcode, shifted_off, pc;
  logic        busy;
  logic [3:0]  rf_raddr_base, rf_raddr_data;
  logic [31:0] rf_rdata_base, rf_rdata_data;
  logic        mem_req, mem_we, mem_size, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rf_wb_en, rf_ld_en;
  logic [3:0]  rf_wb_addr, rf_ld_addr;
  logic [31:0] rf_wb_data, rf_ld_data;

  logic [31:0] regs [16];
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign rf_rdata_base = regs[rf_raddr_base];
  assign rf_rdata_data = regs[rf_raddr_data];

  ldst_xfer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .shifted_off(shifted_off), .pc(pc), .busy(busy),
    .rf_raddr_base(rf_raddr_base), .rf_rdata_base(rf_rdata_base),
    .rf_raddr_data(rf_raddr_data), .rf_rdata_data(rf_rdata_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rf_wb_en(rf_wb_en), .rf_wb_addr(rf_wb_addr),
    .rf_wb_data(rf_wb_data), .rf_ld_en(rf_ld_en), .rf_ld_addr(rf_ld_addr),
    .rf_ld_data(rf_ld_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit i, bit p, bit u, bit b, bit w, bit l,
                                     int rn, int rd, int imm);
    logic [31:0] o;
    o = 32'hE400_0000;
    o[25] = i; o[24] = p; o[23] = u; o[22] = b; o[21] = w; o[20] = l;
    o[19:16] = 4'(rn); o[15:12] = 4'(rd); o[11:0] = 12'(imm);
    return o;
  endfunction

  // one instruction: reference computed behaviourally, compared every clock
  task automatic run(logic [31:0] op, logic [31:0] soff, logic [31:0] p,
                     int lat, logic [31:0] rdat, bit poke);
    longint base, off, nb, ea, val, ld;
    int rn, rd, sh;
    bit l, b, wbk;
    rn = int'(op[19:16]); rd = int'(op[15:12]);
    l = op[20]; b = op[22];
    if (rn == 15) base = longint'(p) + (l ? 12'd8 : 12'd12);
    else base = longint'(regs[rn]);
    off = op[25] ? longint'(soff) : longint'(op[11:0]);
    nb  = op[23] ? (base + off) : (base - off);
    nb  = nb & 64'hFFFF_FFFF;
    ea  = op[24] ? nb : (base & 64'hFFFF_FFFF);
    val = (rd == 15) ? ((longint'(regs[rd]) + 8) & 64'hFFFF_FFFF) : longint'(regs[rd]);
    if (b) val = val % 256;
    sh = int'(ea % 4) * 8;
    if (b) ld = (longint'(rdat) >> sh) % 256;
    else ld = ((longint'(rdat) >> sh) | (longint'(rdat) << (32 - sh))) & 64'hFFFF_FFFF;
    wbk = (!op[24] || op[21]) && !(l && rd == rn);

    @(negedge clk);
    start = 1'b1; opcode = op; shifted_off = soff; pc = p;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= lat; c++) begin
      check("R11 req", {31'd0, mem_req}, 32'd1);
      check("R5 addr", mem_addr, ea[31:0]);
      check("R9 we", {31'd0, mem_we}, {31'd0, !l});
      check("R8 size", {31'd0, mem_size}, {31'd0, !b});
      if (!l) check("R9 wdata", mem_wdata, val[31:0]);
      check("R11 no early wb", {30'd0, rf_wb_en, rf_ld_en}, 32'd0);
      if (c < lat) begin
        if (poke) begin
          start = 1'b1; opcode = mk(0,1,1,0,1,1,1,2,12'h7FC);
        end
        @(negedge clk);
        start = 1'b0;
      end
    end
    mem_ack = 1'b1; mem_rdata = rdat;
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    check("R11 ld pulse", {31'd0, rf_ld_en}, {31'd0, l});
    if (l) begin
      check("R7 R8 ld data", rf_ld_data, ld[31:0]);
      check("R10 ld addr", {28'd0, rf_ld_addr}, 32'(rd));
    end
    check("R6 R10 wb en", {31'd0, rf_wb_en}, {31'd0, wbk});
    if (wbk) begin
      check("R6 wb addr", {28'd0, rf_wb_addr}, 32'(rn));
      check("R4 wb data", rf_wb_data, nb[31:0]);
    end
    @(negedge clk);
    check("R11 single", {29'd0, rf_wb_en, rf_ld_en, mem_req}, 32'd0);
    check("R12 idle", {31'd0, busy}, 32'd0);
    // model the register-file writes
    if (wbk) regs[rn] = nb[31:0];
    if (l) regs[rd] = ld[31:0];
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) regs[k] = 32'h1000_0000 + 32'(k * 32'h100);
    regs[15] = 32'h0000_8000;
    rst_n = 1'b0; start = 1'b0; opcode = '0; shifted_off = '0; pc = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", {29'd0, mem_req, rf_wb_en, rf_ld_en}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {28'd0, busy, mem_req, rf_wb_en, rf_ld_en}, 32'd0);

    // R3 immediate, pre-index add, no writeback, word load aligned
    run(mk(0,1,1,0,0,1,1,2,12'h010), 32'h0, 32'h0, 0, 32'h1122_3344, 0);
    // R7 word load rotations at each lane
    for (int a = 1; a < 4; a++)
      run(mk(0,1,1,0,0,1,3,4,a), 32'h0, 32'h0, 1, 32'hA1B2_C3D4, 0);
    // R8 byte loads from all lanes
    for (int a = 0; a < 4; a++)
      run(mk(0,1,1,1,0,1,5,6,a), 32'h0, 32'h0, 0, 32'h80F1_E2D3, 0);
    // R2 PC base for load and store
    run(mk(0,1,1,0,0,1,15,7,12'h004), 32'h0, 32'h0000_2000, 0, 32'h5555_0001, 0);
    run(mk(0,1,1,0,0,0,15,7,12'h004), 32'h0, 32'h0000_2000, 0, 32'h0, 0);
    // R9 store of r15 and byte store
    run(mk(0,1,0,0,0,0,8,15,12'h020), 32'h0, 32'h0, 0, 32'h0, 0);
    run(mk(0,1,1,1,0,0,8,9,12'h003), 32'h0, 32'h0, 0, 32'h0, 0);
    // R3 register offset, R4 subtract with wraparound, R6 pre with writeback
    regs[10] = 32'h0000_0010;
    run(mk(1,1,0,0,1,1,10,11,0), 32'h0000_0020, 32'h0, 0, 32'hCAFE_F00D, 0);
    // R5 post-index, R6 always writeback, R4 subtract
    run(mk(0,0,0,0,0,0,12,13,12'hFFF), 32'h0, 32'h0, 2, 32'h0, 0);
    // R10 load into its own base with post-index
    run(mk(0,0,1,0,0,1,14,14,12'h008), 32'h0, 32'h0, 0, 32'h0BAD_C0DE, 0);
    run(mk(0,1,1,0,1,1,3,3,12'h004), 32'h0, 32'h0, 0, 32'h1357_9BDF, 0);
    // R12 strobes during a long wait are ignored
    run(mk(0,1,1,0,0,0,4,5,12'h040), 32'h0, 32'h0, 5, 32'h0, 1);
    run(mk(1,0,1,1,0,1,6,0,0), 32'h0000_0003, 32'h0, 4, 32'h99AA_BBCC, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule